// File: doc/BRIEF.md
# Event Monitor with Summary Interrupt

This block watches a parameterised vector of event lines and turns activity on them into per-line pending flags. A compile-time trigger choice selects one of three detection styles for all lines: level (the flag follows the line), rising edge, or falling edge. In the edge styles a flag stays latched until software writes a one to its bit. Each line also has an enable bit. A single summary output goes high whenever some line is both enabled and pending.

Software reaches the two registers through two register-element ports, one for enables and one for pending flags. Each port has a write strobe and write data, plus read data that is always valid. There is no handshake: a write takes effect at the clock edge where its strobe is sampled. Reads have no side effects. All state is reset by the active-low reset.

Top module: `evt_monitor`

## Requirements
- R1: With the trigger set to rise, a line that is sampled at 1 on one edge and was sampled at 0 on the previous edge sets its pending bit, and that bit is visible on pending read data right after that edge.
- R2: With the trigger set to fall, a line that is sampled at 0 on one edge and was sampled at 1 on the previous edge sets its pending bit, and that bit is visible right after that edge.
- R3: With the trigger set to level, each pending bit equals the value its line had at the previous clock edge. A pending write of ones has no effect on it.
- R4: In the edge modes, a pending bit stays set until a pending write carries a one in that bit position. Zero bits in a pending write leave their pending bits unchanged.
- R5: A pending write can never set a pending bit that was clear.
- R6: When a detected edge and a clearing write hit the same bit at the same edge, the bit ends up set.
- R7: The enable register loads the enable write data at an edge where its write strobe is high. Otherwise it holds its value, and it is always readable on enable read data.
- R8: The summary output is high exactly when the bitwise AND of enable and pending is nonzero. It reflects the register values of the current cycle.
- R9: After reset, enable is 0, pending is 0, the summary output is low, and the stored previous input is 0, so a line held at 0 produces no edge.
- R10: In the edge modes, a line held steady after its edge does not set its pending bit again once that bit has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_i | input | N_EVT | Event lines |
| en_wr_stb | input | 1 | Enable register write strobe |
| en_wr_data | input | N_EVT | Enable register write data |
| en_rd_data | output | N_EVT | Enable register read data |
| pnd_wr_stb | input | 1 | Pending register write strobe (write one to clear) |
| pnd_wr_data | input | N_EVT | Pending clear mask |
| pnd_rd_data | output | N_EVT | Pending register read data |
| irq_o | output | 1 | Summary: any enabled bit pending |

## Verification
One instance is built for each trigger mode, and all three are driven with the same event lines, so a single stimulus shows how the modes differ. A single 0-to-1-to-0 pulse on one line sets rise pending first, then fall pending, while the level flag follows the pulse. Directed cases separate clear-by-one from clear-by-zero, try to set bits by writing, put an edge and a clear on the same bit at the same edge, and hold a line steady after it has been cleared. After that, random line patterns with random enable and clear writes check every pending bit and the summary output against a bench model. This covers masking with partial enable sets.

// File: rtl/evt_mon_pkg.sv
package evt_mon_pkg;
  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_RISE  = 2'd1,
    TRIG_FALL  = 2'd2
  } trig_e;
endpackage

// File: rtl/evt_edge_detect.sv
module evt_edge_detect #(
  parameter int                  N_EVT = 8,
  parameter evt_mon_pkg::trig_e  TRIG  = evt_mon_pkg::TRIG_LEVEL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_i,
  output logic [N_EVT-1:0] hit_o
);
  logic [N_EVT-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= evt_i;
  end

  generate
    if (TRIG == evt_mon_pkg::TRIG_RISE) begin : g_rise
      assign hit_o = evt_i & ~prev_q;
      AST_RISE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        |hit_o |-> ((hit_o & ~evt_i) == '0)); // R1
    end else if (TRIG == evt_mon_pkg::TRIG_FALL) begin : g_fall
      assign hit_o = ~evt_i & prev_q;
      AST_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        |hit_o |-> ((hit_o & evt_i) == '0)); // R2
    end else begin : g_level
      assign hit_o = evt_i;
      AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prev_q == $past(evt_i))); // R3
    end
  endgenerate
endmodule

// File: rtl/evt_pend_reg.sv
module evt_pend_reg #(
  parameter int N_EVT = 8,
  parameter bit LEVEL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] set_i,
  input  logic             clr_stb,
  input  logic [N_EVT-1:0] clr_data,
  output logic [N_EVT-1:0] pend_o
);
  logic [N_EVT-1:0] pend_q;
  logic [N_EVT-1:0] pend_d;

  generate
    if (LEVEL) begin : g_level
      assign pend_d = set_i;
      AST_LVL_CLR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> (pend_q == $past(set_i))); // R3
    end else begin : g_edge
      logic [N_EVT-1:0] clr_mask;
      assign clr_mask = clr_stb ? clr_data : '0;
      // set has priority over a simultaneous clear
      assign pend_d = (pend_q & ~clr_mask) | set_i;
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        |set_i |=> ((pend_q & $past(set_i)) == $past(set_i))); // R6
      AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((pend_q & $past(clr_data & ~set_i)) == '0)); // R4
      AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        |(pend_q & ~$past(pend_q)) |-> ((pend_q & ~$past(pend_q) & ~$past(set_i)) == '0)); // R5
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/evt_en_reg.sv
module evt_en_reg #(
  parameter int N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [N_EVT-1:0] wr_data,
  output logic [N_EVT-1:0] en_o
);
  logic [N_EVT-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_stb) en_q <= wr_data;
  end

  assign en_o = en_q;

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(en_q)); // R7
  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (en_q == $past(wr_data))); // R7
endmodule

// File: rtl/evt_monitor.sv
module evt_monitor #(
  parameter int                 N_EVT = 8,
  parameter evt_mon_pkg::trig_e TRIG  = evt_mon_pkg::TRIG_LEVEL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             en_wr_stb,
  input  logic [N_EVT-1:0] en_wr_data,
  output logic [N_EVT-1:0] en_rd_data,
  input  logic             pnd_wr_stb,
  input  logic [N_EVT-1:0] pnd_wr_data,
  output logic [N_EVT-1:0] pnd_rd_data,
  output logic             irq_o
);
  localparam bit IS_LEVEL = (TRIG == evt_mon_pkg::TRIG_LEVEL);

  logic [N_EVT-1:0] hit;
  logic [N_EVT-1:0] pend;
  logic [N_EVT-1:0] en;

  evt_edge_detect #(.N_EVT(N_EVT), .TRIG(TRIG)) u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .evt_i (evt_i),
    .hit_o (hit)
  );

  evt_pend_reg #(.N_EVT(N_EVT), .LEVEL(IS_LEVEL)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (hit),
    .clr_stb  (pnd_wr_stb),
    .clr_data (pnd_wr_data),
    .pend_o   (pend)
  );

  evt_en_reg #(.N_EVT(N_EVT)) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (en_wr_stb),
    .wr_data (en_wr_data),
    .en_o    (en)
  );

  assign irq_o       = |(en & pend);
  assign en_rd_data  = en;
  assign pnd_rd_data = pend;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rd_data == '0) |-> !irq_o); // R8
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (pnd_rd_data == '0) |-> !irq_o); // R8
endmodule

// File: tb/sim_evt_monitor.sv
module sim_evt_monitor;
  localparam int N = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n  = 1'b0;
  logic [N-1:0] evt    = '0;
  logic         en_stb = 1'b0;
  logic [N-1:0] en_d   = '0;
  logic         clr_stb = 1'b0;
  logic [N-1:0] clr_d  = '0;

  logic [N-1:0] en_rd [3];
  logic [N-1:0] pnd_rd [3];
  logic         irq [3];

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [N-1:0] m_prev = '0;
  logic [N-1:0] m_en   = '0;
  logic [N-1:0] m_pend [3] = '{default: '0};

  evt_monitor #(.N_EVT(N), .TRIG(evt_mon_pkg::TRIG_RISE)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .en_wr_stb(en_stb), .en_wr_data(en_d),
    .en_rd_data(en_rd[0]), .pnd_wr_stb(clr_stb), .pnd_wr_data(clr_d),
    .pnd_rd_data(pnd_rd[0]), .irq_o(irq[0]));
  evt_monitor #(.N_EVT(N), .TRIG(evt_mon_pkg::TRIG_FALL)) u1 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .en_wr_stb(en_stb), .en_wr_data(en_d),
    .en_rd_data(en_rd[1]), .pnd_wr_stb(clr_stb), .pnd_wr_data(clr_d),
    .pnd_rd_data(pnd_rd[1]), .irq_o(irq[1]));
  evt_monitor #(.N_EVT(N), .TRIG(evt_mon_pkg::TRIG_LEVEL)) u2 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .en_wr_stb(en_stb), .en_wr_data(en_d),
    .en_rd_data(en_rd[2]), .pnd_wr_stb(clr_stb), .pnd_wr_data(clr_d),
    .pnd_rd_data(pnd_rd[2]), .irq_o(irq[2]));

  // mode 0 = rise, 1 = fall, 2 = level
  function automatic logic [N-1:0] next_pend(int mode, logic [N-1:0] p, logic [N-1:0] prev,
                                             logic [N-1:0] e, logic cs, logic [N-1:0] cd);
    logic [N-1:0] hit;
    logic [N-1:0] clr;
    if (mode == 2) return e;
    hit = (mode == 0) ? (e & ~prev) : (~e & prev);
    clr = cs ? cd : '0;
    return (p & ~clr) | hit;
  endfunction

  task automatic chk(string tag, int inst, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s u%0d: actual %h expected %h", tag, inst, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    string dflt [3] = '{"R1", "R2", "R3"};
    for (int k = 0; k < 3; k++) begin
      chk((tag == "") ? dflt[k] : tag, k, 32'(pnd_rd[k]), 32'(m_pend[k]));
      chk("R7", k, 32'(en_rd[k]), 32'(m_en));
      chk("R8", k, 32'(irq[k]), 32'(|(m_en & m_pend[k])));
    end
  endtask

  task automatic cyc(logic [N-1:0] e, logic es, logic [N-1:0] ed,
                     logic cs, logic [N-1:0] cd, string tag);
    evt = e; en_stb = es; en_d = ed; clr_stb = cs; clr_d = cd;
    @(posedge clk);
    for (int k = 0; k < 3; k++) m_pend[k] = next_pend(k, m_pend[k], m_prev, e, cs, cd);
    m_prev = e;
    if (es) m_en = ed;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R9");                       // R9 reset state
    cyc(8'h00, 1'b0, '0, 1'b0, '0, "R9");  // held-low lines give no edge
    cyc(8'h00, 1'b1, 8'hFF, 1'b0, '0, "R7");
    cyc(8'h01, 1'b0, '0, 1'b0, '0, "");    // R1 rise on u0, R3 level on u2
    cyc(8'h00, 1'b0, '0, 1'b0, '0, "");    // R2 fall on u1
    cyc(8'h00, 1'b0, '0, 1'b1, 8'h00, "R4"); // zero mask keeps bits
    cyc(8'h00, 1'b0, '0, 1'b0, '0, "R4");
    cyc(8'h00, 1'b0, '0, 1'b1, 8'h01, "R4"); // write one clears
    cyc(8'h00, 1'b0, '0, 1'b1, 8'hFF, "R5"); // cannot set clear bits
    cyc(8'h02, 1'b0, '0, 1'b1, 8'h02, "R6"); // edge and clear at once
    cyc(8'h02, 1'b0, '0, 1'b1, 8'h02, "R10");
    cyc(8'h02, 1'b0, '0, 1'b0, '0, "R10");   // held line does not re-set
    cyc(8'h06, 1'b0, '0, 1'b1, 8'h04, "R3"); // level ignores clear
    cyc(8'h06, 1'b0, '0, 1'b1, 8'hFF, "R3");
    cyc(8'h06, 1'b1, 8'h00, 1'b0, '0, "R8"); // all masked
    cyc(8'h06, 1'b1, 8'h80, 1'b0, '0, "R8"); // enable only an idle line
    cyc(8'h86, 1'b0, '0, 1'b0, '0, "R8");
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] e;
      e = N'($urandom);
      cyc(e, ($urandom % 8) == 0, N'($urandom), ($urandom % 3) == 0, N'($urandom), "");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule